// File: doc/BRIEF.md
# CAN Transmit Mailbox Abort Controller

This block tracks the control state of a bank of CAN transmit message buffers and decides what happens when the CPU asks to cancel one. Each buffer has a 4-bit CODE field that the CPU writes through a simple write port. A buffer that is idle accepts any write at once. A buffer that the transmit engine has taken (loaded into its serial transmit buffer or currently on the bus) is locked. A cancel request sent to a locked buffer is held as a pending abort until the transmit engine reports how the frame ended.

A pending abort becomes a real abort if the engine reports lost arbitration, a transmit error, freeze entry, bus-off entry or an overload frame before the frame completes. In that case CODE takes the abort value and the buffer's interrupt flag rises. If the frame completes first, the buffer reports a normal send and the pending request is dropped. A cancel sent before the engine has taken the buffer simply deactivates it. Interrupt flags are write-1-to-clear and feed a masked interrupt output.

Top module: `txab_ctrl`

## Requirements
- R1: After reset every CODE field reads 4'b1000 (transmit inactive), every interrupt flag is 0 and `irq_o` is 0.
- R2: A CODE write to a buffer that is not busy appears on `code_o` in the next cycle exactly as written, without setting the flag, unless R3 applies.
- R3: With `abort_en` set, writing 4'b1001 to a buffer that is not busy makes its CODE 4'b1001 and sets its flag in the next cycle (inactivation).
- R4: A CODE write of any value to a busy buffer is blocked: CODE keeps its value and the buffer stays busy until the engine reports done or an abort event.
- R5: With `abort_en` set, writing 4'b1001 to a busy buffer latches a pending abort. The first abort event (arbitration lost, transmit error, freeze, bus-off, overload) then makes CODE 4'b1001 and sets the flag one cycle later. A request written in the same cycle as the event counts.
- R6: When a busy buffer receives `eng_done`, its CODE becomes 4'b1000 and its flag sets, whether or not an abort was pending. A pending abort is cleared and has no effect on a later transmission.
- R7: An abort event on a busy buffer with no pending abort releases the buffer. CODE stays unchanged and the flag does not set.
- R8: With `abort_en` clear, a 4'b1001 write to a busy buffer is ignored and latches nothing: a following abort event leaves CODE at its prior value and the flag clear.
- R9: Writing 1 to a bit of `flag_clr` clears that flag. A flag set in the same cycle wins over the clear.
- R10: `irq_o` is 1 exactly when some buffer has both its flag and its `irq_mask` bit set.
- R11: `eng_load` marks the buffer at `eng_idx` busy. `eng_done` acts only on the buffer at `eng_idx`, and only if that buffer is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_en | input | 1 | Global abort enable |
| wr_en | input | 1 | CPU CODE write strobe |
| wr_idx | input | IW | Buffer targeted by the write |
| wr_code | input | 4 | CODE value written |
| flag_clr | input | N | Write-1-to-clear for interrupt flags |
| irq_mask | input | N | Per-buffer interrupt enable |
| eng_idx | input | IW | Buffer named by the engine load/done strobes |
| eng_load | input | 1 | Engine copied the buffer into its serial buffer |
| eng_done | input | 1 | Engine finished sending the frame |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| ev_tx_err | input | 1 | Transmit error strobe |
| ev_freeze | input | 1 | Freeze entry strobe |
| ev_busoff | input | 1 | Bus-off entry strobe |
| ev_overload | input | 1 | Overload frame strobe |
| code_o | output | 4*N | CODE fields, buffer i at bits [4i+3:4i] |
| iflag_o | output | N | Interrupt flags |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The assertions assume that the engine pulses `eng_load` only while no buffer is busy, so at most one buffer is ever busy. They also assume that abort events arrive as one-cycle strobes that refer to that busy buffer. The stimulus follows these rules: each scenario loads one buffer, then resolves it with a done or an event before the next load starts. A done strobe aimed at a buffer that is not busy is used on purpose, since the block defines what happens then.

// File: rtl/txab_pkg.sv
package txab_pkg;
  localparam int CW = 4;
  localparam logic [CW-1:0] C_INACT = 4'b1000;
  localparam logic [CW-1:0] C_DATA  = 4'b1100;
  localparam logic [CW-1:0] C_ABORT = 4'b1001;

  function automatic logic is_cancel(input logic en, input logic [CW-1:0] code);
    return en && (code == C_ABORT);
  endfunction

  function automatic logic irq_any(input logic [63:0] flags, input logic [63:0] mask);
    return |(flags & mask);
  endfunction
endpackage

// File: rtl/txab_slot.sv
module txab_slot
  import txab_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_en,
  input  logic          wr_hit,
  input  logic [CW-1:0] wr_code,
  input  logic          clr_hit,
  input  logic          load_hit,
  input  logic          done_hit,
  input  logic          abort_ev,
  output logic [CW-1:0] code_o,
  output logic          flag_o,
  output logic          busy_o
);
  logic [CW-1:0] code_q;
  logic flag_q, busy_q, pend_q;

  logic blocked_wr, pend_req, pend_eff;
  logic sent_fire, abort_fire, drop_fire, inact_fire, accept_wr;

  assign blocked_wr = wr_hit && busy_q;
  assign pend_req   = blocked_wr && is_cancel(abort_en, wr_code);
  assign pend_eff   = pend_q || pend_req;
  assign sent_fire  = busy_q && done_hit;
  assign abort_fire = busy_q && !done_hit && abort_ev && pend_eff;
  assign drop_fire  = busy_q && !done_hit && abort_ev && !pend_eff;
  assign accept_wr  = wr_hit && !busy_q;
  assign inact_fire = accept_wr && is_cancel(abort_en, wr_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= C_INACT;
      flag_q <= 1'b0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (sent_fire)       code_q <= C_INACT;
      else if (abort_fire) code_q <= C_ABORT;
      else if (accept_wr)  code_q <= wr_code;

      if (sent_fire || abort_fire || drop_fire) busy_q <= 1'b0;
      else if (load_hit)                         busy_q <= 1'b1;

      if (sent_fire || abort_fire || drop_fire) pend_q <= 1'b0;
      else if (pend_req)                         pend_q <= 1'b1;

      if (sent_fire || abort_fire || inact_fire) flag_q <= 1'b1;
      else if (clr_hit)                           flag_q <= 1'b0;
    end
  end

  assign code_o = code_q;
  assign flag_o = flag_q;
  assign busy_o = busy_q;

  p_pend_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> busy_q);
  p_abort_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fire |=> (code_q == C_ABORT) && flag_q && !busy_q);
  p_sent_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sent_fire |=> (code_q == C_INACT) && flag_q && !pend_q);
  p_blocked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_wr && !done_hit && !abort_ev) |=> $stable(code_q) && busy_q);
  p_no_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_wr && !abort_en && !pend_q) |=> !pend_q);
  p_drop_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_fire |=> $stable(code_q) && !busy_q);
endmodule

// File: rtl/txab_irq.sv
module txab_irq
  import txab_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] mask,
  output logic         irq
);
  localparam int PADW = 64;
  logic [PADW-1:0] f_pad, m_pad;

  always_comb begin
    f_pad = '0;
    m_pad = '0;
    f_pad[N-1:0] = flags;
    m_pad[N-1:0] = mask;
  end

  assign irq = irq_any(f_pad, m_pad);
endmodule

// File: rtl/txab_ctrl.sv
module txab_ctrl
  import txab_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort_en,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [CW-1:0]   wr_code,
  input  logic [N-1:0]    flag_clr,
  input  logic [N-1:0]    irq_mask,
  input  logic [IW-1:0]   eng_idx,
  input  logic            eng_load,
  input  logic            eng_done,
  input  logic            ev_arb_lost,
  input  logic            ev_tx_err,
  input  logic            ev_freeze,
  input  logic            ev_busoff,
  input  logic            ev_overload,
  output logic [N*CW-1:0] code_o,
  output logic [N-1:0]    iflag_o,
  output logic            irq_o
);
  logic          abort_ev;
  logic [N-1:0]  busy_vec;

  assign abort_ev = ev_arb_lost | ev_tx_err | ev_freeze | ev_busoff | ev_overload;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic wr_hit, load_hit, done_hit;
    assign wr_hit   = wr_en    && (wr_idx  == IW'(i));
    assign load_hit = eng_load && (eng_idx == IW'(i));
    assign done_hit = eng_done && (eng_idx == IW'(i));

    txab_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort_en (abort_en),
      .wr_hit   (wr_hit),
      .wr_code  (wr_code),
      .clr_hit  (flag_clr[i]),
      .load_hit (load_hit),
      .done_hit (done_hit),
      .abort_ev (abort_ev),
      .code_o   (code_o[i*CW +: CW]),
      .flag_o   (iflag_o[i]),
      .busy_o   (busy_vec[i])
    );
  end

  txab_irq #(.N(N)) u_irq (
    .flags (iflag_o),
    .mask  (irq_mask),
    .irq   (irq_o)
  );

  p_single_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_vec));
  p_load_marks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_load && (busy_vec == '0) && !abort_ev && !eng_done) |=> (busy_vec != '0));
endmodule

// File: tb/txab_ctrl_tb_top.sv
`timescale 1ns/1ps
module txab_ctrl_tb_top;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort_en = 1'b0, wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0, eng_idx = '0;
  logic [3:0] wr_code = '0;
  logic [N-1:0] flag_clr = '0, irq_mask = '0;
  logic eng_load = 1'b0, eng_done = 1'b0;
  logic ev_arb_lost = 1'b0, ev_tx_err = 1'b0, ev_freeze = 1'b0, ev_busoff = 1'b0, ev_overload = 1'b0;
  logic [N*4-1:0] code_o;
  logic [N-1:0] iflag_o;
  logic irq_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  txab_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .abort_en(abort_en), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_code(wr_code), .flag_clr(flag_clr), .irq_mask(irq_mask), .eng_idx(eng_idx),
    .eng_load(eng_load), .eng_done(eng_done), .ev_arb_lost(ev_arb_lost),
    .ev_tx_err(ev_tx_err), .ev_freeze(ev_freeze), .ev_busoff(ev_busoff),
    .ev_overload(ev_overload), .code_o(code_o), .iflag_o(iflag_o), .irq_o(irq_o)
  );

  // vector: wcode[13:10] en[9] load[8] ev[7:5] exp_code[4:1] exp_flag[0]
  // ev: 0 none, 1 arb, 2 err, 3 freeze, 4 busoff, 5 overload, 6 done
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {4'b1001, 1'b1, 1'b0, 3'd0, 4'b1001, 1'b1},  // R3
    {4'b1001, 1'b1, 1'b1, 3'd1, 4'b1001, 1'b1},  // R5 arb
    {4'b1001, 1'b1, 1'b1, 3'd2, 4'b1001, 1'b1},  // R5 err
    {4'b1001, 1'b1, 1'b1, 3'd3, 4'b1001, 1'b1},  // R5 freeze
    {4'b1001, 1'b1, 1'b1, 3'd4, 4'b1001, 1'b1},  // R5 busoff
    {4'b1001, 1'b1, 1'b1, 3'd5, 4'b1001, 1'b1},  // R5 overload
    {4'b1001, 1'b1, 1'b1, 3'd6, 4'b1000, 1'b1},  // R6
    {4'b1001, 1'b0, 1'b1, 3'd1, 4'b1100, 1'b0},  // R8
    {4'b0100, 1'b1, 1'b1, 3'd6, 4'b1000, 1'b1},  // R4
    {4'b0010, 1'b1, 1'b0, 3'd0, 4'b0010, 1'b0},  // R2
    {4'b1001, 1'b0, 1'b0, 3'd0, 4'b1001, 1'b0},  // R2 cancel code without enable
    {4'b1100, 1'b1, 1'b1, 3'd1, 4'b1100, 1'b0}   // R7
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input int i);
    return code_o[i*4 +: 4];
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic drive_wr(input int idx, input logic [3:0] c, input logic en);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_code = c; abort_en = en;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic set_ev(input int ev, input int idx, input logic v);
    eng_idx = IW'(idx);
    case (ev)
      1: ev_arb_lost = v;
      2: ev_tx_err   = v;
      3: ev_freeze   = v;
      4: ev_busoff   = v;
      5: ev_overload = v;
      6: eng_done    = v;
      default: ;
    endcase
  endtask

  task automatic fire(input int ev, input int idx);
    set_ev(ev, idx, 1'b1);
    cyc();
    set_ev(ev, idx, 1'b0);
  endtask

  task automatic load(input int idx);
    eng_idx = IW'(idx); eng_load = 1'b1;
    cyc();
    eng_load = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    for (int i = 0; i < N; i++) chk("R1 code", code_of(i), 4'b1000);
    chk("R1 flags", {3'b0, |iflag_o}, 4'd0);
    chk("R1 irq", {3'b0, irq_o}, 4'd0);

    // table walk, buffer index = vector index
    for (int v = 0; v < NV; v++) begin
      logic [13:0] e;
      e = VEC[v];
      drive_wr(v, 4'b1100, 1'b1);
      if (e[8]) load(v);
      drive_wr(v, e[13:10], e[9]);
      if (e[7:5] != 3'd0) fire(int'(e[7:5]), v);
      else cyc();
      chk($sformatf("R2-5 vector %0d code", v), code_of(v), e[4:1]);
      chk($sformatf("vector %0d flag", v), {3'b0, iflag_o[v]}, {3'b0, e[0]});
    end

    // R10 masked interrupt
    irq_mask = '0; cyc();
    chk("R10 all masked", {3'b0, irq_o}, 4'd0);
    irq_mask = 16'h0200; cyc();
    chk("R10 masked flag clear", {3'b0, irq_o}, 4'd0);
    irq_mask = 16'h0001; cyc();
    chk("R10 enabled flag", {3'b0, irq_o}, 4'd1);

    // R9 write-1-to-clear
    flag_clr = 16'h0001; cyc(); flag_clr = '0;
    chk("R9 clear", {3'b0, iflag_o[0]}, 4'd0);
    chk("R10 after clear", {3'b0, irq_o}, 4'd0);
    drive_wr(12, 4'b1100, 1'b1);
    flag_clr = 16'h1000;
    drive_wr(12, 4'b1001, 1'b1);
    flag_clr = '0;
    chk("R9 set wins", {3'b0, iflag_o[12]}, 4'd1);

    // R6 pending dropped after a sent frame
    drive_wr(13, 4'b1100, 1'b1);
    load(13);
    drive_wr(13, 4'b1001, 1'b1);
    fire(6, 13);
    chk("R6 sent code", code_of(13), 4'b1000);
    flag_clr = 16'h2000; cyc(); flag_clr = '0;
    drive_wr(13, 4'b1100, 1'b1);
    load(13);
    fire(1, 13);
    chk("R6 stale pending code", code_of(13), 4'b1100);
    chk("R6 stale pending flag", {3'b0, iflag_o[13]}, 4'd0);
    // R7 released buffer accepts writes
    drive_wr(13, 4'b0010, 1'b1);
    chk("R7 write after release", code_of(13), 4'b0010);

    // R4 / R11 blocked write and done index matching
    drive_wr(14, 4'b1100, 1'b1);
    load(14);
    drive_wr(14, 4'b0001, 1'b1);
    chk("R4 blocked write", code_of(14), 4'b1100);
    fire(6, 15);
    chk("R11 done other index", code_of(14), 4'b1100);
    chk("R11 idle buffer done", code_of(15), 4'b1000);
    fire(6, 14);
    chk("R11 done own index", code_of(14), 4'b1000);

    // R5 request and event in the same cycle
    drive_wr(15, 4'b1100, 1'b1);
    load(15);
    wr_en = 1'b1; wr_idx = 4'd15; wr_code = 4'b1001; abort_en = 1'b1;
    ev_tx_err = 1'b1;
    cyc();
    wr_en = 1'b0; ev_tx_err = 1'b0;
    chk("R5 same cycle code", code_of(15), 4'b1001);
    chk("R5 same cycle flag", {3'b0, iflag_o[15]}, 4'd1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule